// File: doc/BRIEF.md
# Receive Interrupt Moderation Timers

This block decides when a receive interrupt is raised once packets have landed in host memory. Two countdown timers run next to each other. The inter-packet timer restarts on every completed packet, so it fires only after a quiet gap. The absolute timer starts on the first packet of a burst and is not restarted by later packets, so it caps how long a busy stream can hold back an interrupt. Whichever timer expires first raises the interrupt, and that interrupt stops both timers until the next packet arrives.

Software programs each interval through a small write port. Bits 15:0 carry the interval in ticks of an external time base. A zero packet interval turns moderation off: every completed packet raises an interrupt at once. A zero absolute interval leaves only the inter-packet timer in use. A write to the absolute register with bit 31 set sends out a one-cycle request to flush pending descriptor writeback. Interrupts raised by other receive sources stop both timers but are reported elsewhere.

Top module: `rx_irq_moderator`

## Requirements
- R1: After reset `irq_o` and `flush_o` are low, `irq_cause_o` is 0, and both intervals are zero.
- R2: With a nonzero packet interval N, each `pkt_done_i` reloads the packet timer to N. If no further packet arrives, `irq_o` goes high on the edge of the Nth `tick_i` after the loading edge, with cause 1.
- R3: With a packet interval of zero, a `pkt_done_i` cycle gives `irq_o` high on the next cycle with cause 3. Neither timer counts in this mode.
- R4: With a nonzero absolute interval M, the absolute timer loads on a packet only while it is inactive. It fires M ticks after that load with cause 2, even if further packets arrive in between.
- R5: Any interrupt from this block, and any `other_irq_i` pulse, makes both timers inactive. No interrupt follows until another packet completes.
- R6: A write with `cfg_sel_i`=1 and `cfg_wdata_i[31]`=1 gives `flush_o` high for exactly the next cycle. All other writes leave `flush_o` low. Bit 31 never becomes part of an interval.
- R7: A packet that completes in the same cycle as a timer expiry still lets the interrupt through. That packet then starts a new window for both timers.
- R8: When both timers are enabled, the first to expire raises the interrupt. If both expire on the same tick, cause 2 is reported.
- R9: An absolute interval of zero disables the absolute timer. A steady packet stream then never raises an interrupt until the stream stops for the packet interval.
- R10: Timers count only on cycles with `tick_i` high. A tick in the same cycle as a reload is consumed by the reload. Interval writes use `cfg_sel_i`=0 for the packet timer and 1 for the absolute timer, with bits 15:0 holding the value.
- R11: `irq_o` is high for one cycle per interrupt event. `irq_cause_o` is nonzero exactly while `irq_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_wr_en_i | input | 1 | Interval register write strobe |
| cfg_sel_i | input | 1 | Register select: 0 packet interval, 1 absolute interval |
| cfg_wdata_i | input | 32 | Write data: interval in 15:0, flush command in 31 |
| pkt_done_i | input | 1 | One-cycle pulse per packet fully written to memory |
| other_irq_i | input | 1 | Another receive interrupt source fired |
| tick_i | input | 1 | Time-base tick, one cycle per count |
| irq_o | output | 1 | Receive interrupt pulse |
| irq_cause_o | output | 2 | 0 none, 1 packet timer, 2 absolute timer, 3 immediate |
| flush_o | output | 1 | Descriptor writeback flush request pulse |

## Verification
The bound checker watches, on every cycle, the parts of the block that settle in a single step. These are: the cause tag tracking the interrupt pulse, the flush pulse following only a flagged absolute-register write, a packet loading the packet timer, an immediate interrupt when the packet interval is zero, a held count when no tick arrives, and both timers stopping on a foreign interrupt. Behaviours that take many cycles to show can only be seen in the bench scenarios. These include expiry after exactly N ticks, the restart on each packet, the absolute timer ignoring later packets, the race between the two timers, silence after an interrupt, and a packet landing on the expiry cycle. The bench's reference model follows every one of those sequences clock by clock.

// File: rtl/rxim_pkg.sv
package rxim_pkg;
   typedef enum logic [1:0] {
      CAUSE_NONE = 2'd0,
      CAUSE_PKT  = 2'd1,
      CAUSE_ABS  = 2'd2,
      CAUSE_IMM  = 2'd3
   } irq_cause_e;

   localparam logic SEL_PKT = 1'b0;
   localparam logic SEL_ABS = 1'b1;
endpackage

// File: rtl/rxim_cfg_regs.sv
module rxim_cfg_regs
   import rxim_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic             sel_i,
   input  logic [CNT_W-1:0] ival_i,
   input  logic             flush_cmd_i,
   output logic [CNT_W-1:0] pkt_ival_o,
   output logic [CNT_W-1:0] abs_ival_o,
   output logic             flush_o
);
   logic [CNT_W-1:0] pkt_q, abs_q;
   logic             flush_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pkt_q   <= '0;
         abs_q   <= '0;
         flush_q <= 1'b0;
      end else begin
         flush_q <= wr_en_i & (sel_i == SEL_ABS) & flush_cmd_i;
         if (wr_en_i && sel_i == SEL_PKT) pkt_q <= ival_i;
         if (wr_en_i && sel_i == SEL_ABS) abs_q <= ival_i;
      end
   end

   assign pkt_ival_o = pkt_q;
   assign abs_ival_o = abs_q;
   assign flush_o    = flush_q;
endmodule

// File: rtl/rxim_countdown.sv
module rxim_countdown #(
   parameter int CNT_W         = 16,
   parameter bit RELOAD_ALWAYS = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             start_i,
   input  logic             enable_i,
   input  logic             disarm_i,
   input  logic [CNT_W-1:0] ival_i,
   output logic             active_o,
   output logic [CNT_W-1:0] count_o,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   logic             act_q;
   logic [CNT_W-1:0] cnt_q;
   logic             load_w;

   generate
      if (RELOAD_ALWAYS) begin : g_restart
         assign load_w = start_i & enable_i;
      end else begin : g_first_only
         assign load_w = start_i & enable_i & (~act_q | disarm_i);
      end
   endgenerate

   assign expire_o = act_q & tick_i & (cnt_q == LAST);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (load_w) begin
         act_q <= 1'b1;
         cnt_q <= ival_i;
      end else if (disarm_i) begin
         act_q <= 1'b0;
      end else if (act_q && tick_i) begin
         cnt_q <= cnt_q - LAST;
      end
   end

   assign active_o = act_q;
   assign count_o  = cnt_q;
endmodule

// File: rtl/rxim_irq_gen.sv
module rxim_irq_gen
   import rxim_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       pkt_exp_i,
   input  logic       abs_exp_i,
   input  logic       imm_i,
   input  logic       other_i,
   output logic       disarm_o,
   output logic       irq_o,
   output logic [1:0] cause_o
);
   logic       fire_w;
   irq_cause_e cause_w;
   logic       irq_q;
   irq_cause_e cause_q;

   assign fire_w   = pkt_exp_i | abs_exp_i | imm_i;
   assign disarm_o = fire_w | other_i;

   always_comb begin
      if (imm_i)          cause_w = CAUSE_IMM;
      else if (abs_exp_i) cause_w = CAUSE_ABS;
      else if (pkt_exp_i) cause_w = CAUSE_PKT;
      else                cause_w = CAUSE_NONE;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         irq_q   <= 1'b0;
         cause_q <= CAUSE_NONE;
      end else begin
         irq_q   <= fire_w;
         cause_q <= cause_w;
      end
   end

   assign irq_o   = irq_q;
   assign cause_o = cause_q;
endmodule

// File: rtl/rx_irq_moderator.sv
module rx_irq_moderator
   import rxim_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int DATA_W    = 32,
   parameter int FLUSH_BIT = 31
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cfg_wr_en_i,
   input  logic              cfg_sel_i,
   input  logic [DATA_W-1:0] cfg_wdata_i,
   input  logic              pkt_done_i,
   input  logic              other_irq_i,
   input  logic              tick_i,
   output logic              irq_o,
   output logic [1:0]        irq_cause_o,
   output logic              flush_o
);
   generate
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("CNT_W must lie in 1..DATA_W");
      end
      if (FLUSH_BIT >= DATA_W || FLUSH_BIT < CNT_W) begin : g_bad_flush_bit
         $error("FLUSH_BIT must sit above the interval field and inside DATA_W");
      end
   endgenerate

   logic [CNT_W-1:0] pkt_ival_w, abs_ival_w;
   logic [CNT_W-1:0] pkt_cnt_w, abs_cnt_w;
   logic             pkt_act_w, abs_act_w;
   logic             pkt_exp_w, abs_exp_w;
   logic             pkt_en_w, abs_en_w, imm_w, disarm_w;
   logic             unused_wdata_w;

   assign unused_wdata_w = ^cfg_wdata_i;

   rxim_cfg_regs #(.CNT_W(CNT_W)) regs_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (cfg_wr_en_i),
      .sel_i      (cfg_sel_i),
      .ival_i     (cfg_wdata_i[CNT_W-1:0]),
      .flush_cmd_i(cfg_wdata_i[FLUSH_BIT]),
      .pkt_ival_o (pkt_ival_w),
      .abs_ival_o (abs_ival_w),
      .flush_o    (flush_o)
   );

   assign pkt_en_w = (pkt_ival_w != '0);
   assign abs_en_w = pkt_en_w & (abs_ival_w != '0);
   assign imm_w    = pkt_done_i & ~pkt_en_w;

   rxim_countdown #(.CNT_W(CNT_W), .RELOAD_ALWAYS(1'b1)) pkt_tmr_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .start_i (pkt_done_i),
      .enable_i(pkt_en_w),
      .disarm_i(disarm_w),
      .ival_i  (pkt_ival_w),
      .active_o(pkt_act_w),
      .count_o (pkt_cnt_w),
      .expire_o(pkt_exp_w)
   );

   rxim_countdown #(.CNT_W(CNT_W), .RELOAD_ALWAYS(1'b0)) abs_tmr_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .start_i (pkt_done_i),
      .enable_i(abs_en_w),
      .disarm_i(disarm_w),
      .ival_i  (abs_ival_w),
      .active_o(abs_act_w),
      .count_o (abs_cnt_w),
      .expire_o(abs_exp_w)
   );

   rxim_irq_gen irq_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pkt_exp_i(pkt_exp_w),
      .abs_exp_i(abs_exp_w),
      .imm_i    (imm_w),
      .other_i  (other_irq_i),
      .disarm_o (disarm_w),
      .irq_o    (irq_o),
      .cause_o  (irq_cause_o)
   );
endmodule

// File: rtl/rxim_chk.sv
module rxim_chk
   import rxim_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int DATA_W    = 32,
   parameter int FLUSH_BIT = 31
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              cfg_wr_en_i,
   input logic              cfg_sel_i,
   input logic [DATA_W-1:0] cfg_wdata_i,
   input logic              pkt_done_i,
   input logic              other_irq_i,
   input logic              tick_i,
   input logic              irq_o,
   input logic [1:0]        irq_cause_o,
   input logic              flush_o,
   input logic [CNT_W-1:0]  pkt_ival_i,
   input logic              pkt_act_i,
   input logic [CNT_W-1:0]  pkt_cnt_i,
   input logic              abs_act_i,
   input logic [CNT_W-1:0]  abs_cnt_i,
   input logic              disarm_i
);
   logic flush_wr_w;
   assign flush_wr_w = cfg_wr_en_i && (cfg_sel_i == SEL_ABS) && cfg_wdata_i[FLUSH_BIT];

   // R11
   cause_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> irq_cause_o != CAUSE_NONE);
   // R11
   cause_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_o |-> irq_cause_o == CAUSE_NONE);
   // R5
   other_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      other_irq_i && !pkt_done_i |=> !pkt_act_i && !abs_act_i);
   // R6
   flush_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_wr_w |=> flush_o);
   // R6
   flush_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !flush_wr_w |=> !flush_o);
   // R4
   abs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abs_act_i && !disarm_i && !tick_i |=> abs_act_i && $stable(abs_cnt_i));
   // R2
   pkt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pkt_done_i && pkt_ival_i != '0 |=> pkt_act_i && pkt_cnt_i == $past(pkt_ival_i));
   // R3
   imm_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pkt_done_i && pkt_ival_i == '0 |=> irq_o && irq_cause_o == CAUSE_IMM);
   // R10
   tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pkt_act_i && !tick_i && !pkt_done_i && !disarm_i |=> $stable(pkt_cnt_i));
endmodule

bind rx_irq_moderator rxim_chk #(
   .CNT_W(CNT_W), .DATA_W(DATA_W), .FLUSH_BIT(FLUSH_BIT)
) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .cfg_wr_en_i(cfg_wr_en_i),
   .cfg_sel_i  (cfg_sel_i),
   .cfg_wdata_i(cfg_wdata_i),
   .pkt_done_i (pkt_done_i),
   .other_irq_i(other_irq_i),
   .tick_i     (tick_i),
   .irq_o      (irq_o),
   .irq_cause_o(irq_cause_o),
   .flush_o    (flush_o),
   .pkt_ival_i (pkt_ival_w),
   .pkt_act_i  (pkt_act_w),
   .pkt_cnt_i  (pkt_cnt_w),
   .abs_act_i  (abs_act_w),
   .abs_cnt_i  (abs_cnt_w),
   .disarm_i   (disarm_w)
);

// File: tb/rx_irq_moderator_tb_top.sv
`timescale 1ns/1ps
module rx_irq_moderator_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        sel = 1'b0;
   logic [31:0] wdata = '0;
   logic        pkt = 1'b0;
   logic        other = 1'b0;
   logic        tick = 1'b1;
   logic        irq;
   logic [1:0]  cause;
   logic        flush;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rx_irq_moderator dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cfg_wr_en_i(wr_en), .cfg_sel_i(sel),
      .cfg_wdata_i(wdata), .pkt_done_i(pkt), .other_irq_i(other), .tick_i(tick),
      .irq_o(irq), .irq_cause_o(cause), .flush_o(flush)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Behavioural reference model: remaining ticks per timer, updated per edge.
   int m_piv = 0, m_aiv = 0, m_prem = 0, m_arem = 0;
   bit m_pon = 0, m_aon = 0;
   bit e_irq = 0, e_flush = 0;
   int e_cause = 0;

   always @(posedge clk) begin
      bit pe, ae, im, off;
      if (!rst_n) begin
         m_piv = 0; m_aiv = 0; m_pon = 0; m_aon = 0; m_prem = 0; m_arem = 0;
         e_irq = 0; e_flush = 0; e_cause = 0;
      end else begin
         pe = m_pon && tick && (m_prem == 1);
         ae = m_aon && tick && (m_arem == 1);
         im = pkt && (m_piv == 0);
         e_irq = pe || ae || im;
         e_cause = im ? 3 : ae ? 2 : pe ? 1 : 0;
         off = e_irq || other;
         if (pkt && m_piv != 0) begin m_pon = 1; m_prem = m_piv; end
         else if (off) m_pon = 0;
         else if (m_pon && tick) m_prem--;
         if (pkt && m_piv != 0 && m_aiv != 0 && (!m_aon || off)) begin m_aon = 1; m_arem = m_aiv; end
         else if (off) m_aon = 0;
         else if (m_aon && tick) m_arem--;
         e_flush = wr_en && sel && wdata[31];
         if (wr_en && !sel) m_piv = int'(wdata[15:0]);
         if (wr_en && sel)  m_aiv = int'(wdata[15:0]);
      end
   end

   function automatic string tag_of(input int c);
      return (c == 3) ? "R3" : (c == 2) ? "R4" : (c == 1) ? "R2" : "R5";
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(irq === e_irq, {tag_of(e_cause), " irq"}, int'(irq), int'(e_irq));
         check(int'(cause) == e_cause, "R11 cause", int'(cause), e_cause);
         check(flush === e_flush, "R6 flush", int'(flush), int'(e_flush));
      end
   end

   task automatic wr(input bit s, input logic [31:0] d);
      wr_en = 1'b1; sel = s; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   // Drive a packet pattern; k counts edges from the first drive.
   task automatic run(input int period, input int npk, input int other_k, input int tdiv,
                      input int ncyc, output int first, output int second, output int hits,
                      output int cause1);
      first = -1; second = -1; hits = 0; cause1 = 0;
      for (int k = 0; k < ncyc; k++) begin
         pkt   = (k % period == 0) && (k / period < npk);
         other = (k == other_k);
         tick  = (k % tdiv == 0);
         @(negedge clk);
         if (irq) begin
            hits++;
            if (first < 0) begin first = k; cause1 = int'(cause); end
            else if (second < 0) second = k;
         end
      end
      pkt = 1'b0; other = 1'b0; tick = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int f, s, h, c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(irq == 1'b0, "R1 irq", int'(irq), 0);
      check(flush == 1'b0, "R1 flush", int'(flush), 0);
      check(cause == 2'd0, "R1 cause", int'(cause), 0);

      // R3 zero packet interval: immediate interrupt
      run(1, 1, -1, 1, 5, f, s, h, c);
      check(f == 0, "R3 latency", f, 0);
      check(c == 3, "R3 cause", c, 3);
      check(h == 1, "R3 count", h, 1);

      // R2 single packet, interval 4
      wr(1'b0, 32'd4);
      run(100, 1, -1, 1, 12, f, s, h, c);
      check(f == 4, "R2 latency", f, 4);
      check(c == 1, "R2 cause", c, 1);

      // R2 restart on each packet
      wr(1'b0, 32'd6);
      run(3, 3, -1, 1, 20, f, s, h, c);
      check(f == 12, "R2 restart latency", f, 12);
      check(h == 1, "R2 restart count", h, 1);

      // R10 tick every second cycle; tick on load cycle is consumed
      wr(1'b0, 32'd3);
      run(100, 1, -1, 2, 12, f, s, h, c);
      check(f == 6, "R10 slow tick latency", f, 6);

      // R4 absolute timer not reloaded by later packets
      wr(1'b0, 32'd10);
      wr(1'b1, 32'd8);
      run(3, 100, -1, 1, 9, f, s, h, c);
      check(f == 8, "R4 latency", f, 8);
      check(c == 2, "R4 cause", c, 2);
      // R5 silent after interrupt
      run(100, 0, -1, 1, 30, f, s, h, c);
      check(h == 0, "R5 quiet after irq", h, 0);

      // R8 packet timer wins, absolute stays quiet afterwards
      wr(1'b0, 32'd3);
      wr(1'b1, 32'd20);
      run(100, 1, -1, 1, 30, f, s, h, c);
      check(f == 3 && c == 1, "R8 first expiry", f * 10 + c, 31);
      check(h == 1, "R8 single irq", h, 1);

      // R8 both expire together: absolute cause reported
      wr(1'b0, 32'd5);
      wr(1'b1, 32'd5);
      run(100, 1, -1, 1, 10, f, s, h, c);
      check(f == 5 && c == 2, "R8 tie", f * 10 + c, 52);

      // R5 other interrupt disarms both
      wr(1'b1, 32'd0);
      run(100, 1, 2, 1, 20, f, s, h, c);
      check(h == 0, "R5 other disarm", h, 0);
      run(100, 1, -1, 1, 8, f, s, h, c);
      check(f == 5, "R5 rearm on packet", f, 5);

      // R7 packet on expiry cycle starts a new window
      wr(1'b0, 32'd4);
      run(4, 2, -1, 1, 12, f, s, h, c);
      check(f == 4, "R7 first", f, 4);
      check(s == 8, "R7 second", s, 8);
      check(h == 2, "R7 count", h, 2);

      // R9 absolute disabled: steady stream holds off the interrupt
      wr(1'b0, 32'd5);
      run(3, 6, -1, 1, 25, f, s, h, c);
      check(f == 20, "R9 latency", f, 20);
      check(h == 1, "R9 count", h, 1);

      // R6 flush command only on absolute register writes
      wr(1'b1, 32'h8000_0007);
      check(flush == 1'b1, "R6 flush pulse", int'(flush), 1);
      @(negedge clk);
      check(flush == 1'b0, "R6 flush one cycle", int'(flush), 0);
      wr(1'b0, 32'h8000_0003);
      check(flush == 1'b0, "R6 packet reg no flush", int'(flush), 0);
      wr(1'b1, 32'h0000_0009);
      check(flush == 1'b0, "R6 clear bit no flush", int'(flush), 0);
      // R6 R10 bit 31 not part of interval: absolute 9, packet 3
      run(2, 100, -1, 1, 10, f, s, h, c);
      check(f == 9 && c == 2, "R6 interval field", f * 10 + c, 92);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule